// File: doc/BRIEF.md
# Pixel Run Fill/Copy Engine

The engine draws short horizontal runs of 8-bit pixels into a byte-addressed frame memory. It is driven by word writes from a host. A write with word-address bit 2 clear loads a colour latch and draws nothing. A write with bit 2 set is a command.

In a command, the destination pixel comes from the host word address. The command word holds a run length and a source pixel address. A source equal to the all-ones code turns the command into a fill with the latched colour. Any other source value makes it a byte copy.

The engine walks the run one byte at a time through a valid/ready memory port. It stays busy and holds off the host until the run is finished. At the end it pulses a dirty report giving the destination and length of the run, which the display side uses to redraw.

Top module: `pixel_run_blitter`

## Requirements
- R1: A host write with `host_word_addr[2]` = 0 stores `host_wdata[7:0]` as the fill colour. The upper data bits have no effect. It causes no memory request, does not raise `busy` and gives no dirty pulse.
- R2: A host write with `host_word_addr[2]` = 1 is a command. The destination is `host_word_addr[22:3]`, zero-extended to the memory address width. The run length is `host_wdata[28:24]` + 1 (1 to 32). `host_wdata[31:29]` are ignored.
- R3: When `host_wdata[23:0]` = 24'hFFFFFF the command is a fill. It issues only writes, to destination+0, +1, … in ascending order, each carrying the latched colour.
- R4: Any other source value is a copy. For k = 0 … len-1, byte (source+k) is read and then written to (destination+k), with addresses taken modulo 2^24. Because the order is strict, an overlapping copy with source below destination repeats the leading bytes.
- R5: A memory request (`mem_valid`, `mem_we`, `mem_addr`, `mem_wdata`) stays unchanged until `mem_ready` is seen high at a clock edge. Read data is taken from `mem_rdata` in the cycle the read is accepted.
- R6: `busy` rises in the cycle after a command is accepted and `host_ready` is low while `busy` is high, so both command and colour writes wait. With memory always ready, `busy` lasts len+1 cycles for a fill and 2·len+1 cycles for a copy.
- R7: Exactly one `dirty_valid` pulse of one cycle marks the end of each command. It carries `dirty_addr` = destination and `dirty_len` = run length, and `busy` falls on the next cycle.
- R8: Host reads are accepted like writes and return zero. They cause no drawing and no memory request.
- R9: After reset the engine is idle: `busy`, `mem_valid` and `dirty_valid` are low, `host_ready` is high, and the colour latch holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word_addr | input | 21 | Host word address, bits [22:2] |
| host_wdata | input | 32 | Host write data (colour or command) |
| host_ready | output | 1 | Access accepted at this edge when high with `host_req` |
| host_rdata | output | 32 | Read data, always zero |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the accepting cycle |
| busy | output | 1 | A command is in progress |
| dirty_valid | output | 1 | One-cycle end-of-run report |
| dirty_addr | output | 24 | First modified byte |
| dirty_len | output | 6 | Number of modified bytes |

## Verification
A corrupted run index or base register shows up at the memory port during the run itself. On the first wrong handshake, the address leaves the expected ascending sequence or the byte differs from the reference image. A wrong fill/copy flag shows as a read request where only writes belong, or as a missing read before a write. A bad length or a sequencer stuck in one state shows only at the end of the run, as a dirty report with the wrong length, a missing or doubled pulse, or a busy window of the wrong number of cycles.

// File: rtl/blitter_pkg.sv
// Package: shared constants and types for the pixel run engine.
// Holds the command-word layout, which is fixed by the host programming
// model, plus the sequencer state encoding.
package blitter_pkg;

    localparam int SRC_W   = 24;                 // source field width
    localparam int LENF_W  = 5;                  // length-minus-one field width
    localparam int RUN_W   = LENF_W + 1;         // holds 1..32
    localparam int LEN_LSB = SRC_W;              // length field position
    localparam logic [SRC_W-1:0] FILL_CODE = '1; // reserved source: fill

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic             fill;
        logic [SRC_W-1:0] src;
        logic [RUN_W-1:0] run;
    } blit_cmd_t;

endpackage

// File: rtl/blit_cmd_decode.sv
// Module: blit_cmd_decode
// Splits a host write into colour-latch or command, and unpacks the command.
// Assumes MEM_AW >= SRC_W and MEM_AW >= HOST_AW-3. Purely combinational.
module blit_cmd_decode
    import blitter_pkg::*;
#(
    parameter int HOST_AW = 23,
    parameter int MEM_AW  = 24
) (
    input  logic [HOST_AW-1:2] word_addr,
    input  logic [31:0]        wdata,
    output logic               is_cmd,
    output logic [MEM_AW-1:0]  dest,
    output blit_cmd_t          cmd
);
    localparam int DEST_W = HOST_AW - 3;

    logic [SRC_W-1:0]  src_field;
    logic [LENF_W-1:0] len_field;
    logic              unused_rsvd;

    assign src_field   = wdata[SRC_W-1:0];
    assign len_field   = wdata[LEN_LSB +: LENF_W];
    assign unused_rsvd = &{1'b0, wdata[31:LEN_LSB+LENF_W]};

    // Purpose: address bit 2 separates commands from colour loads.
    always_comb begin
        is_cmd = word_addr[2];
    end

    // Purpose: zero-extend the destination pixel index.
    always_comb begin
        dest = '0;
        dest[DEST_W-1:0] = word_addr[HOST_AW-1:3];
    end

    // Purpose: unpack length, source and the fill code.
    always_comb begin
        cmd.src  = src_field;
        cmd.run  = {1'b0, len_field} + RUN_W'(1);
        cmd.fill = (src_field == FILL_CODE);
    end
endmodule

// File: rtl/blit_sequencer.sv
// Module: blit_sequencer
// Runs one command: per pixel a read then a write for copies, a write
// only for fills, in ascending order, over a valid/ready byte port.
// Assumes start only arrives while idle and colour is stable while busy.
module blit_sequencer
    import blitter_pkg::*;
#(
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] start_dest,
    input  blit_cmd_t         start_cmd,
    input  logic [7:0]        colour,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              fire_last,
    output logic [MEM_AW-1:0] run_dest,
    output logic [RUN_W-1:0]  run_len
);
    seq_state_t        state_q;
    logic [MEM_AW-1:0] dst_q;
    logic [MEM_AW-1:0] src_q;
    logic [RUN_W-1:0]  run_q;
    logic [RUN_W-1:0]  idx_q;
    logic              fill_q;
    logic [7:0]        hold_q;
    logic [MEM_AW-1:0] src_ext;
    logic [MEM_AW-1:0] offset;
    logic              last_px;

    // Purpose: widen the command source to the memory address width.
    always_comb begin
        src_ext = '0;
        src_ext[SRC_W-1:0] = start_cmd.src;
    end

    assign offset  = MEM_AW'(idx_q);
    assign last_px = ((idx_q + RUN_W'(1)) == run_q);

    // Purpose: drive the memory request from state and run position.
    always_comb begin
        mem_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_READ) ? (src_q + offset) : (dst_q + offset);
        mem_wdata = fill_q ? colour : hold_q;
    end

    assign busy      = (state_q != ST_IDLE);
    assign fire_last = (state_q == ST_WRITE) && mem_ready && last_px;
    assign run_dest  = dst_q;
    assign run_len   = run_q;

    // Purpose: step through the run, one handshake at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dst_q   <= '0;
            src_q   <= '0;
            run_q   <= '0;
            idx_q   <= '0;
            fill_q  <= 1'b0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        dst_q   <= start_dest;
                        src_q   <= src_ext;
                        run_q   <= start_cmd.run;
                        fill_q  <= start_cmd.fill;
                        idx_q   <= '0;
                        state_q <= start_cmd.fill ? ST_WRITE : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        hold_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (last_px) begin
                            state_q <= ST_DONE;
                        end else begin
                            idx_q   <= idx_q + RUN_W'(1);
                            state_q <= fill_q ? ST_WRITE : ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: a stalled request keeps every field.
    assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R3: a fill never reads.
    assert_fill_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && fill_q) |-> mem_we);

    // R4: an accepted read is followed at once by a write.
    assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we));

    // R4: writes stay inside the destination run.
    assert_write_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> ((mem_addr - dst_q) < MEM_AW'(run_q)));
endmodule

// File: rtl/blit_dirty_report.sv
// Module: blit_dirty_report
// Registers the end-of-run report: one-cycle pulse with destination and
// length, raised in the cycle after the last write is accepted.
module blit_dirty_report
    import blitter_pkg::*;
#(
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_last,
    input  logic [MEM_AW-1:0] run_dest,
    input  logic [RUN_W-1:0]  run_len,
    output logic              dirty_valid,
    output logic [MEM_AW-1:0] dirty_addr,
    output logic [RUN_W-1:0]  dirty_len
);
    // Purpose: capture the finished run and pulse once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_valid <= 1'b0;
            dirty_addr  <= '0;
            dirty_len   <= '0;
        end else begin
            dirty_valid <= fire_last;
            if (fire_last) begin
                dirty_addr <= run_dest;
                dirty_len  <= run_len;
            end
        end
    end

    // R7: the report lasts a single cycle.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |=> !dirty_valid);
endmodule

// File: rtl/pixel_run_blitter.sv
// Module: pixel_run_blitter (top)
// Host-programmed fill/copy engine for 8-bit pixel runs. Holds the colour
// latch, gates host accesses with busy, and joins decoder, sequencer and
// dirty report. Assumes the memory answers reads in the accepting cycle.
module pixel_run_blitter
    import blitter_pkg::*;
#(
    parameter int HOST_AW = 23,
    parameter int MEM_AW  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:2] host_word_addr,
    input  logic [31:0]        host_wdata,
    output logic               host_ready,
    output logic [31:0]        host_rdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic               busy,
    output logic               dirty_valid,
    output logic [MEM_AW-1:0]  dirty_addr,
    output logic [RUN_W-1:0]   dirty_len
);
    logic              is_cmd;
    logic [MEM_AW-1:0] cmd_dest;
    blit_cmd_t         cmd;
    logic [7:0]        colour_q;
    logic              accept;
    logic              start;
    logic              fire_last;
    logic [MEM_AW-1:0] run_dest;
    logic [RUN_W-1:0]  run_len;

    assign host_ready = !busy;
    assign host_rdata = '0;
    assign accept     = host_req && host_ready;
    assign start      = accept && host_we && is_cmd;

    // Purpose: load the fill colour on an accepted non-command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_q <= '0;
        end else if (accept && host_we && !is_cmd) begin
            colour_q <= host_wdata[7:0];
        end
    end

    blit_cmd_decode #(.HOST_AW(HOST_AW), .MEM_AW(MEM_AW)) u_decode (
        .word_addr (host_word_addr),
        .wdata     (host_wdata),
        .is_cmd    (is_cmd),
        .dest      (cmd_dest),
        .cmd       (cmd)
    );

    blit_sequencer #(.MEM_AW(MEM_AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_dest (cmd_dest),
        .start_cmd  (cmd),
        .colour     (colour_q),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .fire_last  (fire_last),
        .run_dest   (run_dest),
        .run_len    (run_len)
    );

    blit_dirty_report #(.MEM_AW(MEM_AW)) u_dirty (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_last   (fire_last),
        .run_dest    (run_dest),
        .run_len     (run_len),
        .dirty_valid (dirty_valid),
        .dirty_addr  (dirty_addr),
        .dirty_len   (dirty_len)
    );

    // R6: busy only starts from an accepted command write.
    assert_busy_from_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_req && host_we && host_word_addr[2]));

    // R9: no memory traffic while idle.
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);

    // R7: the report ends the busy window.
    assert_dirty_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> (busy && !mem_valid) ##1 !busy);

    // R1: a colour load never starts drawing.
    assert_colour_no_draw_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && host_we && !host_word_addr[2]) |=> !busy);
endmodule

// File: tb/pixel_run_blitter_test.sv
`timescale 1ns/1ps
module pixel_run_blitter_test;
    localparam int HOST_AW = 23;
    localparam int MEM_AW  = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [20:0] host_word_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic        dirty_valid;
    logic [23:0] dirty_addr;
    logic [5:0]  dirty_len;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    pixel_run_blitter #(.HOST_AW(HOST_AW), .MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_word_addr(host_word_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .dirty_valid(dirty_valid), .dirty_addr(dirty_addr),
        .dirty_len(dirty_len)
    );

    // Memory model: 4 KiB window, aliasing on the low 12 address bits.
    logic [7:0]  mem  [0:4095];
    logic [7:0]  refm [0:4095];
    logic [15:0] lfsr = 16'hACE1;
    bit          stall_mode = 1'b0;

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready <= stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4096; k++) mem[k] <= 8'(k * 7 + 3);
        end else if (mem_valid && mem_ready && mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    // Monitor: ordering of handshakes, busy length, dirty reports.
    bit          mon_clear = 1'b0;
    int          rd_k, wr_k, busy_cyc, dirty_cnt;
    bit          order_bad;
    logic [23:0] exp_src, exp_dst, got_daddr;
    logic [5:0]  got_dlen;
    bit          exp_fill;

    always @(posedge clk) begin
        if (mon_clear) begin
            rd_k <= 0; wr_k <= 0; busy_cyc <= 0; dirty_cnt <= 0; order_bad <= 1'b0;
        end else begin
            if (busy) busy_cyc <= busy_cyc + 1;
            if (dirty_valid) begin
                dirty_cnt <= dirty_cnt + 1;
                got_daddr <= dirty_addr;
                got_dlen  <= dirty_len;
            end
            if (mem_valid && mem_ready) begin
                if (!mem_we) begin
                    if (exp_fill || mem_addr != exp_src + 24'(rd_k) || rd_k != wr_k)
                        order_bad <= 1'b1;
                    rd_k <= rd_k + 1;
                end else begin
                    if (mem_addr != exp_dst + 24'(wr_k) || (!exp_fill && rd_k != wr_k + 1))
                        order_bad <= 1'b1;
                    wr_k <= wr_k + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) mon_clear = 1'b1;
        @(negedge clk) mon_clear = 1'b0;
    endtask

    task automatic host_xfer(input bit we, input logic [20:0] wa, input logic [31:0] d,
                             output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_word_addr = wa; host_wdata = d;
        while (!host_ready) @(negedge clk);
        rd = host_rdata;
        @(posedge clk);
        #1;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    logic [7:0] cur_colour = 8'h00;

    task automatic set_colour(input logic [7:0] c);
        logic [31:0] rd;
        host_xfer(1'b1, {20'h5A5A5, 1'b0}, {24'hC3A511, c}, rd);
        cur_colour = c;
    endtask

    task automatic ref_apply(input logic [19:0] dst, input logic [31:0] cmd);
        int len = int'(cmd[28:24]) + 1;
        bit fl = (cmd[23:0] == 24'hFFFFFF);
        for (int k = 0; k < len; k++) begin
            logic [23:0] da = 24'(dst) + 24'(k);
            logic [23:0] sa = cmd[23:0] + 24'(k);
            refm[da[11:0]] = fl ? cur_colour : refm[sa[11:0]];
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_image(input string req);
        int mism = 0;
        int first = -1;
        for (int k = 0; k < 4096; k++)
            if (mem[k] !== refm[k]) begin
                mism++;
                if (first < 0) first = k;
            end
        chk(mism == 0, req, first < 0 ? 0 : mem[first], first < 0 ? 0 : refm[first]);
    endtask

    // One command with full checks; timed adds the busy-length check (R6).
    task automatic run_op(input logic [19:0] dst, input logic [31:0] cmd,
                          input string req, input bit timed);
        logic [31:0] rd;
        int len = int'(cmd[28:24]) + 1;
        bit fl = (cmd[23:0] == 24'hFFFFFF);
        ref_apply(dst, cmd);
        exp_src = cmd[23:0]; exp_dst = 24'(dst); exp_fill = fl;
        clear_mon();
        host_xfer(1'b1, {dst, 1'b1}, cmd, rd);
        wait_idle();
        check_image(req);
        chk(!order_bad && rd_k == (fl ? 0 : len) && wr_k == len,
            {req, " order"}, wr_k, len);
        chk(dirty_cnt == 1 && got_daddr == 24'(dst) && got_dlen == 6'(len),
            "R7 dirty report", {got_daddr, 2'b0, got_dlen}, {24'(dst), 2'b0, 6'(len)});
        if (timed)
            chk(busy_cyc == (fl ? len + 1 : 2 * len + 1), "R6 busy cycles",
                busy_cyc, fl ? len + 1 : 2 * len + 1);
    endtask

    initial begin
        logic [31:0] rd;
        for (int k = 0; k < 4096; k++) refm[k] = 8'(k * 7 + 3);
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(!busy && !mem_valid && !dirty_valid && host_ready, "R9 reset idle",
            {busy, mem_valid, dirty_valid, host_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: latch is 0 after reset, so a fill with no colour load writes 0
        run_op(20'd10, {3'b0, 5'd3, 24'hFFFFFF}, "R9 reset colour", 1'b0);

        // R8: reads return zero and do nothing
        clear_mon();
        host_xfer(1'b0, {20'd77, 1'b1}, 32'hFFFF_FFFF, rd);
        chk(rd == 32'd0, "R8 read data", rd, 0);
        host_xfer(1'b0, {20'd77, 1'b0}, 32'h0, rd);
        repeat (3) @(negedge clk);
        chk(rd == 32'd0 && rd_k + wr_k == 0 && busy_cyc == 0 && dirty_cnt == 0,
            "R8 read no effect", rd_k + wr_k + busy_cyc, 0);

        // R1: colour load draws nothing
        clear_mon();
        set_colour(8'h5D);
        repeat (3) @(negedge clk);
        chk(rd_k + wr_k == 0 && busy_cyc == 0 && dirty_cnt == 0, "R1 latch no draw",
            rd_k + wr_k + busy_cyc + dirty_cnt, 0);
        check_image("R1 image unchanged");

        // R6: exact busy length with an always-ready memory
        run_op(20'd300, {3'b0, 5'd4, 24'hFFFFFF}, "R3 timed fill", 1'b1);
        run_op(20'd340, {3'b0, 5'd6, 24'd700}, "R4 timed copy", 1'b1);
        run_op(20'd380, {3'b0, 5'd0, 24'd701}, "R4 single copy", 1'b1);

        // Stalling memory for the sweeps (R5)
        stall_mode = 1'b1;
        repeat (2) @(negedge clk);
        for (int len = 1; len <= 32; len++) begin
            set_colour(8'(len * 9 + 1));
            run_op(20'(len * 80), {3'b0, 5'(len - 1), 24'hFFFFFF}, "R3 fill sweep", 1'b0);
        end
        for (int len = 1; len <= 32; len++)
            run_op(20'(len * 64), {3'b0, 5'(len - 1), 24'(2600 + len * 40)},
                   "R4 copy sweep", 1'b0);

        // R4: overlaps and the source next to the fill code
        run_op(20'd3900, {3'b0, 5'd7, 24'd3899}, "R4 overlap up", 1'b0);
        run_op(20'd3950, {3'b0, 5'd9, 24'd3953}, "R4 overlap down", 1'b0);
        run_op(20'd3700, {3'b0, 5'd3, 24'hFFFFFE}, "R4 source FFFFFE wraps", 1'b0);

        // R2: reserved command bits ignored, length field max
        set_colour(8'hE7);
        run_op(20'd4000, {3'b111, 5'd2, 24'hFFFFFF}, "R2 reserved bits", 1'b0);
        run_op(20'd4050, {3'b101, 5'd31, 24'd100}, "R2 max length", 1'b0);

        // R6: writes stall while busy; colour cannot change mid-run
        set_colour(8'h3C);
        ref_apply(20'd1000, {3'b0, 5'd31, 24'hFFFFFF});
        exp_src = 24'hFFFFFF; exp_dst = 24'd1000; exp_fill = 1'b1;
        clear_mon();
        host_xfer(1'b1, {20'd1000, 1'b1}, {3'b0, 5'd31, 24'hFFFFFF}, rd);
        @(negedge clk);
        chk(busy && !host_ready, "R6 host held off", {busy, host_ready}, 2'b10);
        set_colour(8'hC3);
        chk(dirty_cnt == 1, "R6 colour waited for run end", dirty_cnt, 1);
        wait_idle();
        check_image("R6 run used old colour");
        run_op(20'd1100, {3'b0, 5'd3, 24'hFFFFFF}, "R3 new colour", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog R6 actual=hung expected=idle");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule